// File: doc/BRIEF.md
# Shift and rotate unit

A width-parameterized unit that moves the bits of one operand left or right by a variable count. A 3-bit operation select picks logical shift, arithmetic shift or rotate, in either direction. Alongside the result it returns a carry bit. For shifts, the carry bit is the last bit pushed off the end of the operand. For rotates, it is the last bit that wrapped around to the other end.

The datapath is purely combinational. A parameter-selected output stage then either registers the result and the carry on the rising clock edge, or passes them straight through. The default is 8 bits wide with the output stage enabled. The count input is one bit wider than needed to index the operand, so counts at and beyond the width can be requested and have a defined result.

Top module: `shift_rotate_unit`

## Requirements
- R1: Select 000 is a logical right shift by n. Vacated high bits become 0 and the carry is operand bit n-1. For example, 10100110 by 3 gives 00010100 with carry 1.
- R2: Select 001 is a logical left shift by n. Vacated low bits become 0 and the carry is operand bit WIDTH-n. For example, 10100110 by 3 gives 00110000 with carry 1.
- R3: Select 010 is an arithmetic right shift by n. Vacated high bits copy the original top bit and the carry is operand bit n-1. For example, 10100110 by 3 gives 11110100 with carry 1.
- R4: Select 011 is an arithmetic left shift by n. The top bit stays where it is, and the lower WIDTH-1 bits shift left with zero fill. The carry is operand bit WIDTH-1-n. For example, 10100110 by 3 gives 10110000 with carry 0.
- R5: Select 100 rotates right and select 101 rotates left, each by n modulo WIDTH. The carry is the last bit wrapped: result bit WIDTH-1 for a right rotate and result bit 0 for a left rotate. For example, 10100110 by 3 gives 11010100 (right) and 00110101 (left), both with carry 1.
- R6: A shift count at or above WIDTH saturates:
  - Logical shifts give all zeros.
  - The arithmetic right shift gives all copies of the top bit, with carry equal to the top bit.
  - The arithmetic left shift gives the top bit followed by zeros, with carry 0.
  - A logical shift of exactly WIDTH carries the last operand bit pushed out. A larger count carries 0.
- R7: A count of zero returns the operand unchanged with carry 0, whatever the select.
- R8: Selects 110 and 111 return the operand unchanged with carry 0, for any count.
- R9: With the output stage enabled, the result and carry appear one clock after the inputs are presented. A synchronous active-high reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output stage |
| rst_i | input | 1 | Synchronous active-high reset of the output stage |
| op_i | input | 3 | Operation select |
| cnt_i | input | $clog2(WIDTH)+1 | Shift or rotate count |
| a_i | input | WIDTH | Operand |
| res_o | output | WIDTH | Result |
| cout_o | output | 1 | Last bit shifted out or wrapped |

## Verification
Every result and carry is due exactly one rising edge after the operand, count and select are applied, because the only register on the path is the output stage. The bench changes inputs on the falling edge and compares the outputs at the next falling edge, half a period after the capturing edge. A reset is checked in the same way, one edge after it is raised. The properties use a one-cycle implication against the inputs sampled on the previous edge.

// File: rtl/srot_pkg.sv
package srot_pkg;
  typedef enum logic [2:0] {
    OP_LSR   = 3'b000,
    OP_LSL   = 3'b001,
    OP_ASR   = 3'b010,
    OP_ASL   = 3'b011,
    OP_ROR   = 3'b100,
    OP_ROL   = 3'b101,
    OP_PASSA = 3'b110,
    OP_PASSB = 3'b111
  } srot_op_e;
endpackage

// File: rtl/srot_shift.sv
module srot_shift #(
  parameter int WIDTH = 8,
  parameter int CW    = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [CW-1:0]    cnt,
  input  logic             to_right,
  input  logic             arith,
  output logic [WIDTH-1:0] res,
  output logic             cout
);
  localparam int LOW_W = WIDTH - 1;

  function automatic logic bit_at(input logic [WIDTH-1:0] v, input int idx);
    logic [WIDTH-1:0] t;
    if (idx < 0 || idx >= WIDTH) return 1'b0;
    t = v >> idx;
    return t[0];
  endfunction

  // Right shift, fill with zero or with the top bit.
  function automatic logic [WIDTH:0] shr(input logic [WIDTH-1:0] v, input int n,
                                         input logic fill);
    logic [WIDTH-1:0] r;
    logic             c;
    r = v >> n;
    if (fill) r = r | ~({WIDTH{1'b1}} >> n);
    if (n == 0)          c = 1'b0;
    else if (n <= WIDTH) c = bit_at(v, n - 1);
    else                 c = fill;
    return {c, r};
  endfunction

  // Left shift; keep_top holds the top bit and shifts only the bits below it.
  function automatic logic [WIDTH:0] shl(input logic [WIDTH-1:0] v, input int n,
                                         input logic keep_top);
    logic [WIDTH-1:0] r;
    logic [LOW_W-1:0] lo;
    logic             c;
    int               span;
    span = keep_top ? LOW_W : WIDTH;
    if (keep_top) begin
      lo = v[LOW_W-1:0] << n;
      r  = {v[WIDTH-1], lo};
    end else begin
      r  = v << n;
    end
    if (n == 0 || n > span) c = 1'b0;
    else                    c = bit_at(v, span - n);
    return {c, r};
  endfunction

  logic [WIDTH:0] packed_out;
  always_comb begin
    if (to_right) packed_out = shr(a, int'(cnt), arith & a[WIDTH-1]);
    else          packed_out = shl(a, int'(cnt), arith);
  end

  assign res  = packed_out[WIDTH-1:0];
  assign cout = packed_out[WIDTH];
endmodule

// File: rtl/srot_rotate.sv
module srot_rotate #(
  parameter int WIDTH = 8,
  parameter int CW    = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [CW-1:0]    cnt,
  input  logic             to_right,
  output logic [WIDTH-1:0] res,
  output logic             cout
);
  function automatic logic [WIDTH-1:0] rot(input logic [WIDTH-1:0] v, input int m,
                                           input logic right);
    if (m == 0) return v;
    if (right) return (v >> m) | (v << (WIDTH - m));
    return (v << m) | (v >> (WIDTH - m));
  endfunction

  int amount;
  assign amount = int'(cnt) % WIDTH;

  assign res  = rot(a, amount, to_right);
  assign cout = (cnt == '0) ? 1'b0 : (to_right ? res[WIDTH-1] : res[0]);
endmodule

// File: rtl/srot_outreg.sv
module srot_outreg #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_res,
  input  logic             d_cout,
  output logic [WIDTH-1:0] q_res,
  output logic             q_cout
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          q_res  <= '0;
          q_cout <= 1'b0;
        end else begin
          q_res  <= d_res;
          q_cout <= d_cout;
        end
      end
    end else begin : g_comb
      assign q_res  = d_res;
      assign q_cout = d_cout;
    end
  endgenerate
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import srot_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int CW     = $clog2(WIDTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [2:0]       op_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  srot_op_e op;
  assign op = srot_op_e'(op_i);

  // Named decode events, used by the datapath mux and visible to the checker.
  logic op_is_rot, op_is_pass, cnt_zero;
  assign op_is_rot  = (op == OP_ROR) || (op == OP_ROL);
  assign op_is_pass = (op == OP_PASSA) || (op == OP_PASSB);
  assign cnt_zero   = (cnt_i == '0);

  logic             dir_right, arith;
  assign dir_right = (op == OP_LSR) || (op == OP_ASR) || (op == OP_ROR);
  assign arith     = (op == OP_ASR) || (op == OP_ASL);

  logic [WIDTH-1:0] sh_res, rt_res, comb_res;
  logic             sh_cout, rt_cout, comb_cout;

  srot_shift #(.WIDTH(WIDTH), .CW(CW)) u_shift (
    .a(a_i), .cnt(cnt_i), .to_right(dir_right), .arith(arith),
    .res(sh_res), .cout(sh_cout)
  );

  srot_rotate #(.WIDTH(WIDTH), .CW(CW)) u_rotate (
    .a(a_i), .cnt(cnt_i), .to_right(dir_right),
    .res(rt_res), .cout(rt_cout)
  );

  always_comb begin
    if (op_is_pass || cnt_zero) begin
      comb_res  = a_i;
      comb_cout = 1'b0;
    end else if (op_is_rot) begin
      comb_res  = rt_res;
      comb_cout = rt_cout;
    end else begin
      comb_res  = sh_res;
      comb_cout = sh_cout;
    end
  end

  srot_outreg #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
    .clk_i(clk_i), .rst_i(rst_i),
    .d_res(comb_res), .d_cout(comb_cout),
    .q_res(res_o), .q_cout(cout_o)
  );
endmodule

// File: rtl/srot_checker.sv
module srot_checker #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int CW     = $clog2(WIDTH) + 1
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [2:0]       op_i,
  input logic [CW-1:0]    cnt_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] res_o,
  input logic             cout_o,
  input logic             op_is_rot,
  input logic             cnt_zero
);
  generate
    if (REG_OUT) begin : g_props
      a_r9_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (res_o == '0 && !cout_o));

      a_r7_zero_count: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_zero |=> (res_o == $past(a_i) && !cout_o));

      a_r8_passthrough: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i[2:1] == 2'b11) |=> (res_o == $past(a_i) && !cout_o));

      a_r3_asr_keeps_sign: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == 3'b010) |=> (res_o[WIDTH-1] == $past(a_i[WIDTH-1])));

      a_r4_asl_keeps_sign: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == 3'b011) |=> (res_o[WIDTH-1] == $past(a_i[WIDTH-1])));

      a_r5_rotate_keeps_ones: assert property (@(posedge clk_i) disable iff (rst_i)
        op_is_rot |=> ($countones(res_o) == $countones($past(a_i))));

      a_r1_lsr_top_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == 3'b000 && !cnt_zero) |=> !res_o[WIDTH-1]);
    end
  endgenerate
endmodule

bind shift_rotate_unit srot_checker #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .op_i(op_i), .cnt_i(cnt_i), .a_i(a_i),
  .res_o(res_o), .cout_o(cout_o), .op_is_rot(op_is_rot), .cnt_zero(cnt_zero)
);

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;
  localparam int W  = 8;
  localparam int CW = $clog2(W) + 1;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    op;
  logic [CW-1:0] cnt;
  logic [W-1:0]  a;
  logic [W-1:0]  res;
  logic          cout;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  shift_rotate_unit #(.WIDTH(W), .REG_OUT(1'b1)) u_dut (
    .clk_i(clk), .rst_i(rst), .op_i(op), .cnt_i(cnt), .a_i(a),
    .res_o(res), .cout_o(cout)
  );

  // Reference: apply the operation one bit position at a time, n times.
  function automatic logic [W:0] model(input logic [2:0] o, input int n,
                                       input logic [W-1:0] v);
    logic [W-1:0] r = v;
    logic         c = 1'b0;
    if (o[2:1] == 2'b11) return {1'b0, v};
    for (int k = 0; k < n; k++) begin
      case (o)
        3'd0: begin c = r[0];   r = {1'b0, r[W-1:1]}; end
        3'd1: begin c = r[W-1]; r = {r[W-2:0], 1'b0}; end
        3'd2: begin c = r[0];   r = {r[W-1], r[W-1:1]}; end
        3'd3: begin c = r[W-2]; r = {r[W-1], r[W-3:0], 1'b0}; end
        3'd4: begin c = r[0];   r = {r[0], r[W-1:1]}; end
        default: begin c = r[W-1]; r = {r[W-2:0], r[W-1]}; end
      endcase
    end
    return {c, r};
  endfunction

  function automatic string req_of(input logic [2:0] o, input int n);
    if (n == 0) return "R7";
    case (o)
      3'd0: return (n >= W) ? "R6" : "R1";
      3'd1: return (n >= W) ? "R6" : "R2";
      3'd2: return (n >= W) ? "R6" : "R3";
      3'd3: return (n >= W) ? "R6" : "R4";
      3'd4, 3'd5: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [W-1:0] exp_r, input logic exp_c);
    n_checks++;
    if (res !== exp_r || cout !== exp_c) begin
      n_errors++;
      $display("FAIL %s: got res=%b cout=%b, expected res=%b cout=%b",
               tag, res, cout, exp_r, exp_c);
    end
  endtask

  // Drive on a falling edge; the result is captured at the next rising edge
  // and compared at the falling edge after it.
  task automatic run(input logic [2:0] o, input int n, input logic [W-1:0] v);
    logic [W:0] e;
    @(negedge clk);
    op = o; cnt = CW'(n); a = v;
    e = model(o, n, v);
    @(negedge clk);
    compare(req_of(o, n), e[W-1:0], e[W]);
  endtask

  task automatic run_exp(input string tag, input logic [2:0] o, input int n,
                         input logic [W-1:0] v, input logic [W-1:0] er, input logic ec);
    @(negedge clk);
    op = o; cnt = CW'(n); a = v;
    @(negedge clk);
    compare(tag, er, ec);
  endtask

  initial begin
    rst = 1'b1; op = '0; cnt = '0; a = '0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    compare("R9 reset", '0, 1'b0);
    rst = 1'b0;

    // Directed values for 10100110 shifted or rotated by 3.
    run_exp("R1 lsr", 3'd0, 3, 8'b10100110, 8'b00010100, 1'b1);
    run_exp("R2 lsl", 3'd1, 3, 8'b10100110, 8'b00110000, 1'b1);
    run_exp("R3 asr", 3'd2, 3, 8'b10100110, 8'b11110100, 1'b1);
    run_exp("R4 asl", 3'd3, 3, 8'b10100110, 8'b10110000, 1'b0);
    run_exp("R5 ror", 3'd4, 3, 8'b10100110, 8'b11010100, 1'b1);
    run_exp("R5 rol", 3'd5, 3, 8'b10100110, 8'b00110101, 1'b1);
    run_exp("R5 rol mod", 3'd5, 11, 8'b10100110, 8'b00110101, 1'b1);
    run_exp("R5 ror full", 3'd4, 8, 8'b10100110, 8'b10100110, 1'b1);

    // Saturation.
    run_exp("R6 lsr W", 3'd0, 8, 8'b10100110, 8'h00, 1'b1);
    run_exp("R6 lsr >W", 3'd0, 15, 8'hFF, 8'h00, 1'b0);
    run_exp("R6 lsl W", 3'd1, 8, 8'b10100111, 8'h00, 1'b1);
    run_exp("R6 asr >W", 3'd2, 12, 8'b10000000, 8'hFF, 1'b1);
    run_exp("R6 asr pos", 3'd2, 9, 8'b01111111, 8'h00, 1'b0);
    run_exp("R6 asl >W", 3'd3, 10, 8'hFF, 8'h80, 1'b0);

    // Zero count and pass-through selects.
    for (int o = 0; o < 8; o++)
      run_exp("R7 zero count", 3'(o), 0, 8'b11001011, 8'b11001011, 1'b0);
    run_exp("R8 pass 110", 3'd6, 5, 8'h5A, 8'h5A, 1'b0);
    run_exp("R8 pass 111", 3'd7, 13, 8'hC3, 8'hC3, 1'b0);

    // Constrained random: every select, full count range.
    for (int k = 0; k < 400; k++)
      run(3'($urandom_range(0, 7)), int'($urandom_range(0, 15)), 8'($urandom));

    // Reset in the middle of traffic clears the registered outputs.
    @(negedge clk);
    op = 3'd5; cnt = 4'd1; a = 8'hFF; rst = 1'b1;
    @(negedge clk);
    compare("R9 reset mid-run", '0, 1'b0);
    rst = 1'b0;
    run(3'd1, 1, 8'h81);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule